// File: doc/BRIEF.md
# Bus Error Capture and Logging Unit

This unit sits beside the master engine of a PCI-X-style host interface and watches the error strobes that engine raises. When one of these strobes fires, the unit stores a diagnostic record of the failing transaction. The strobes are a detected data parity error, a master-abort, a target-abort, an exceeded retry limit, a split response time-out and a split completion error. The record holds the 64-bit address as two 32-bit words, the transaction attributes, the command code, a class code naming the event, and the split completion message when the event involves a split completion.

Only the first error is kept. Any later error is counted only through a sticky overflow bit and per-class "seen" bits, and the record stays as it is until software clears it through a small register port. The unit also produces the response for each class. Aborts and retry exhaustion answer the far-side read with all-ones data and an acknowledge. A parity error pulses a parity-error strobe when reporting is enabled. A level interrupt request stays raised while a record is held and interrupts are enabled.

Top module: `berr_log_unit`

## Requirements
- R1: After reset every register reads zero, and irq_o, perr_o, far_ack_o and far_data_o are low.
- R2: Register offsets are: 0 = address upper word, 1 = address lower word, 2 = attributes (zero-extended), 3 = split message, 4 = status, 5 = control. The first event after an empty record loads the address, attributes and command into the record.
- R3: Status layout: bit 0 valid, bit 1 overflow, bits 6:4 class code, bits 11:8 command, bits 21:16 seen bits. Class codes: 1 parity, 2 master-abort, 3 target-abort, 4 retry limit, 5 split time-out, 6 split completion error. Seen bit 16+code-1 belongs to each class.
- R4: While valid is set, a new event leaves the address, attributes, command, class and message unchanged and sets overflow.
- R5: When several events arrive in one cycle, the class with the lowest code is recorded and overflow is set. The seen bit of every arriving event is set.
- R6: Writing status with bit 0 set clears valid, overflow, class, seen bits and all record fields, and the next event is captured again.
- R7: One cycle after a master-abort, target-abort or retry-limit event, far_ack_o is high for one cycle and far_data_o is all ones. Otherwise both are zero.
- R8: One cycle after a parity event, perr_o pulses only if control bit 1 is set. The parity event is logged either way.
- R9: The split message register loads split_msg_i when the recorded class is 5 or 6. For any other class it loads zero.
- R10: irq_o is high exactly while valid is set and control bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| par_err_i | input | 1 | Data parity error detected |
| mabort_i | input | 1 | Master-abort received |
| tabort_i | input | 1 | Target-abort received |
| retry_exc_i | input | 1 | Retry count limit exceeded |
| split_to_i | input | 1 | Split response time-out |
| split_cerr_i | input | 1 | Split completion error indicated |
| txn_addr_i | input | ADDR_W | Address of the current transaction |
| txn_attr_i | input | ATTR_W | Attributes of the current transaction |
| txn_cmd_i | input | 4 | Command code of the current transaction |
| split_msg_i | input | MSG_W | Split completion message |
| reg_addr_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| far_ack_o | output | 1 | Data acknowledge toward the far-side bus |
| far_data_o | output | DATA_W | Read data toward the far-side bus |
| perr_o | output | 1 | Parity error strobe |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The bound checker watches several properties on every cycle. An interrupt never appears without a held record. Aborts and retry exhaustion are always followed by an all-ones acknowledge. A parity strobe only follows a parity event. A held record stays frozen and overflow stays sticky until a clear. A clear with no event empties the record. Only the bench scenarios can show the exact field values that were captured, the class chosen among simultaneous events, the contents of the seen bits, the gating of the parity strobe by the control bit, and the routing of the split message for each class.

// File: rtl/berr_pkg.sv
package berr_pkg;
  localparam int NCLS   = 6;
  localparam int CLS_W  = 3;
  localparam int CMD_W  = 4;
  localparam int REG_AW = 3;

  // event vector index = priority (0 highest) = class code - 1
  localparam int EV_PAR   = 0;
  localparam int EV_MABT  = 1;
  localparam int EV_TABT  = 2;
  localparam int EV_RETRY = 3;
  localparam int EV_SPLTO = 4;
  localparam int EV_SPLCE = 5;

  typedef enum logic [CLS_W-1:0] {
    CLS_NONE  = 3'd0,
    CLS_PAR   = 3'd1,
    CLS_MABT  = 3'd2,
    CLS_TABT  = 3'd3,
    CLS_RETRY = 3'd4,
    CLS_SPLTO = 3'd5,
    CLS_SPLCE = 3'd6
  } err_cls_e;

  typedef enum logic [REG_AW-1:0] {
    REG_ADDR_HI = 3'd0,
    REG_ADDR_LO = 3'd1,
    REG_ATTR    = 3'd2,
    REG_SMSG    = 3'd3,
    REG_STAT    = 3'd4,
    REG_CTRL    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/berr_prio.sv
module berr_prio
  import berr_pkg::*;
#(
  parameter int N = NCLS
) (
  input  logic [N-1:0] ev_i,
  output err_cls_e     cls_o,
  output logic         any_o,
  output logic         multi_o
);
  logic [CLS_W-1:0] code;

  always_comb begin
    code = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ev_i[i]) code = CLS_W'(i + 1);
    end
  end

  assign cls_o   = err_cls_e'(code);
  assign any_o   = |ev_i;
  assign multi_o = ($countones(ev_i) > 1);
endmodule

// File: rtl/berr_record.sv
module berr_record
  import berr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ATTR_W = 32,
  parameter int MSG_W  = 32,
  parameter int N      = NCLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [N-1:0]      ev_i,
  input  err_cls_e          cls_i,
  input  logic              any_i,
  input  logic              multi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ATTR_W-1:0] attr_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [MSG_W-1:0]  msg_i,
  output logic              valid_o,
  output logic              ovf_o,
  output err_cls_e          cls_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ATTR_W-1:0] attr_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [MSG_W-1:0]  msg_o,
  output logic [N-1:0]      seen_o
);
  logic armed, is_split;

  // a clear in the same cycle re-arms before the event is judged
  assign armed    = !valid_o || clr_i;
  assign is_split = (cls_i == CLS_SPLTO) || (cls_i == CLS_SPLCE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
      cls_o   <= CLS_NONE;
      addr_o  <= '0;
      attr_o  <= '0;
      cmd_o   <= '0;
      msg_o   <= '0;
      seen_o  <= '0;
    end else begin
      if (clr_i) begin
        valid_o <= 1'b0;
        ovf_o   <= 1'b0;
        cls_o   <= CLS_NONE;
        addr_o  <= '0;
        attr_o  <= '0;
        cmd_o   <= '0;
        msg_o   <= '0;
      end
      if (any_i && armed) begin
        valid_o <= 1'b1;
        ovf_o   <= multi_i;
        cls_o   <= cls_i;
        addr_o  <= addr_i;
        attr_o  <= attr_i;
        cmd_o   <= cmd_i;
        msg_o   <= is_split ? msg_i : '0;
      end else if (any_i) begin
        ovf_o   <= 1'b1;
      end
      seen_o <= (clr_i ? '0 : seen_o) | ev_i;
    end
  end
endmodule

// File: rtl/berr_resp.sv
module berr_resp
  import berr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N      = NCLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      ev_i,
  input  logic              perr_en_i,
  output logic              far_ack_o,
  output logic [DATA_W-1:0] far_data_o,
  output logic              perr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      far_ack_o <= 1'b0;
      perr_o    <= 1'b0;
    end else begin
      far_ack_o <= ev_i[EV_MABT] | ev_i[EV_TABT] | ev_i[EV_RETRY];
      perr_o    <= ev_i[EV_PAR] & perr_en_i;
    end
  end

  assign far_data_o = {DATA_W{far_ack_o}};
endmodule

// File: rtl/berr_log_unit.sv
module berr_log_unit
  import berr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ATTR_W = 32,
  parameter int MSG_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              par_err_i,
  input  logic              mabort_i,
  input  logic              tabort_i,
  input  logic              retry_exc_i,
  input  logic              split_to_i,
  input  logic              split_cerr_i,
  input  logic [ADDR_W-1:0] txn_addr_i,
  input  logic [ATTR_W-1:0] txn_attr_i,
  input  logic [3:0]        txn_cmd_i,
  input  logic [MSG_W-1:0]  split_msg_i,
  input  logic [2:0]        reg_addr_i,
  input  logic              reg_we_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              far_ack_o,
  output logic [DATA_W-1:0] far_data_o,
  output logic              perr_o,
  output logic              irq_o
);
  localparam int HI_W = ADDR_W - 32;

  logic [NCLS-1:0]   ev;
  err_cls_e          prio_cls, rec_cls;
  logic              ev_any, ev_multi, clr;
  logic              rec_valid, rec_ovf;
  logic [ADDR_W-1:0] rec_addr;
  logic [ATTR_W-1:0] rec_attr;
  logic [CMD_W-1:0]  rec_cmd;
  logic [MSG_W-1:0]  rec_msg;
  logic [NCLS-1:0]   rec_seen;
  logic [1:0]        ctrl_q;   // [0] irq enable, [1] parity report enable
  logic [31:0]       stat_word;

  assign ev  = {split_cerr_i, split_to_i, retry_exc_i, tabort_i, mabort_i, par_err_i};
  assign clr = reg_we_i && (reg_addr_i == REG_STAT) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                    ctrl_q <= '0;
    else if (reg_we_i && reg_addr_i == REG_CTRL)    ctrl_q <= reg_wdata_i[1:0];
  end

  berr_prio #(.N(NCLS)) u_prio (
    .ev_i    (ev),
    .cls_o   (prio_cls),
    .any_o   (ev_any),
    .multi_o (ev_multi)
  );

  berr_record #(
    .ADDR_W (ADDR_W),
    .ATTR_W (ATTR_W),
    .MSG_W  (MSG_W),
    .N      (NCLS)
  ) u_rec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .ev_i    (ev),
    .cls_i   (prio_cls),
    .any_i   (ev_any),
    .multi_i (ev_multi),
    .addr_i  (txn_addr_i),
    .attr_i  (txn_attr_i),
    .cmd_i   (txn_cmd_i),
    .msg_i   (split_msg_i),
    .valid_o (rec_valid),
    .ovf_o   (rec_ovf),
    .cls_o   (rec_cls),
    .addr_o  (rec_addr),
    .attr_o  (rec_attr),
    .cmd_o   (rec_cmd),
    .msg_o   (rec_msg),
    .seen_o  (rec_seen)
  );

  berr_resp #(.DATA_W(DATA_W), .N(NCLS)) u_resp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ev_i       (ev),
    .perr_en_i  (ctrl_q[1]),
    .far_ack_o  (far_ack_o),
    .far_data_o (far_data_o),
    .perr_o     (perr_o)
  );

  assign stat_word = {10'b0, rec_seen, 4'b0, rec_cmd, 1'b0, rec_cls, 2'b0, rec_ovf, rec_valid};

  always_comb begin
    case (reg_addr_i)
      REG_ADDR_HI: reg_rdata_o = 32'(rec_addr[ADDR_W-1 -: HI_W]);
      REG_ADDR_LO: reg_rdata_o = rec_addr[31:0];
      REG_ATTR:    reg_rdata_o = 32'(rec_attr);
      REG_SMSG:    reg_rdata_o = 32'(rec_msg);
      REG_STAT:    reg_rdata_o = stat_word;
      REG_CTRL:    reg_rdata_o = {30'b0, ctrl_q};
      default:     reg_rdata_o = '0;
    endcase
  end

  assign irq_o = rec_valid & ctrl_q[0];
endmodule

// File: rtl/berr_log_chk.sv
module berr_log_chk #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [5:0]        ev_i,
  input logic              clr_i,
  input logic              valid_i,
  input logic              ovf_i,
  input logic [ADDR_W-1:0] rec_addr_i,
  input logic              far_ack_i,
  input logic [DATA_W-1:0] far_data_i,
  input logic              perr_i,
  input logic              irq_i
);
  // R10
  irq_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> valid_i);
  // R7
  abort_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i[1] || ev_i[2] || ev_i[3]) |=> far_ack_i);
  // R7
  ack_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_ack_i |-> (&far_data_i));
  // R8
  perr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_i |-> $past(ev_i[0]));
  // R4
  hold_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !clr_i) |=> (valid_i && $stable(rec_addr_i)));
  // R4
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i && !clr_i) |=> ovf_i);
  // R6
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ev_i == '0) |=> (!valid_i && !ovf_i));
endmodule

bind berr_log_unit berr_log_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ev_i       (ev),
  .clr_i      (clr),
  .valid_i    (rec_valid),
  .ovf_i      (rec_ovf),
  .rec_addr_i (rec_addr),
  .far_ack_i  (far_ack_o),
  .far_data_i (far_data_o),
  .perr_i     (perr_o),
  .irq_i      (irq_o)
);

// File: tb/sim_berr_log_unit.sv
`timescale 1ns/1ps
module sim_berr_log_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ev = '0;
  logic [63:0] addr = '0;
  logic [31:0] attr = '0;
  logic [3:0]  cmd = '0;
  logic [31:0] msg = '0;
  logic [2:0]  raddr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ack, perr, irq;
  logic [31:0] fdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // kind: 0 register read, 1 irq, 2 perr, 3 ack, 4 far data
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  berr_log_unit u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .par_err_i(ev[0]), .mabort_i(ev[1]), .tabort_i(ev[2]),
    .retry_exc_i(ev[3]), .split_to_i(ev[4]), .split_cerr_i(ev[5]),
    .txn_addr_i(addr), .txn_attr_i(attr), .txn_cmd_i(cmd), .split_msg_i(msg),
    .reg_addr_i(raddr), .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .far_ack_o(ack), .far_data_o(fdata), .perr_o(perr), .irq_o(irq)
  );

  function automatic logic [31:0] st(bit v, bit o, logic [2:0] c, logic [3:0] m, logic [5:0] s);
    return {10'b0, s, 4'b0, m, 1'b0, c, 2'b0, o, v};
  endfunction

  // monitor: compare just after each rising edge
  initial forever begin
    @(posedge clk);
    #1;
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {31'b0, irq};
        2: act = {31'b0, perr};
        3: act = {31'b0, ack};
        default: act = fdata;
      endcase
      total++;
      if (act !== it.exp) begin
        bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic expect_out(int kind, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic rd(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    raddr = a;
    expect_out(0, exp, tag);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic fire(logic [5:0] e, logic [63:0] a, logic [31:0] at, logic [3:0] c, logic [31:0] m);
    @(negedge clk);
    ev = e; addr = a; attr = at; cmd = c; msg = m;
  endtask

  task automatic quiet();
    @(negedge clk);
    ev = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd4, 32'h0, "R1");
    expect_out(1, 0, "R1"); expect_out(2, 0, "R1");
    expect_out(3, 0, "R1"); expect_out(4, 0, "R1");
    rd(3'd0, 32'h0, "R1");
    rd(3'd1, 32'h0, "R1");

    wr(3'd5, 32'h3);
    rd(3'd5, 32'h3, "R10");

    // master-abort: first capture
    fire(6'b000010, 64'h1234_5678_9abc_def0, 32'h0055_aa01, 4'h6, 32'hdead_beef);
    expect_out(3, 1, "R7"); expect_out(4, 32'hffff_ffff, "R7"); expect_out(2, 0, "R8");
    quiet();
    expect_out(3, 0, "R7"); expect_out(4, 0, "R7");
    rd(3'd0, 32'h1234_5678, "R2");
    rd(3'd1, 32'h9abc_def0, "R2");
    rd(3'd2, 32'h0055_aa01, "R2");
    rd(3'd3, 32'h0, "R9");
    rd(3'd4, st(1, 0, 3'd2, 4'h6, 6'b000010), "R3");
    expect_out(1, 1, "R10");

    // later retry: record held, overflow set
    fire(6'b001000, 64'hffff_0000_ffff_0000, 32'h1, 4'h3, 32'h0);
    expect_out(3, 1, "R7");
    quiet();
    rd(3'd1, 32'h9abc_def0, "R4");
    rd(3'd2, 32'h0055_aa01, "R4");
    rd(3'd4, st(1, 1, 3'd2, 4'h6, 6'b001010), "R4");

    // clear
    wr(3'd4, 32'h1);
    rd(3'd4, 32'h0, "R6");
    expect_out(1, 0, "R6");
    rd(3'd0, 32'h0, "R6");

    // parity with reporting enabled
    fire(6'b000001, 64'h0000_0001_0000_0040, 32'h7, 4'h7, 32'h0);
    expect_out(2, 1, "R8"); expect_out(3, 0, "R7");
    quiet();
    expect_out(2, 0, "R8");
    rd(3'd4, st(1, 0, 3'd1, 4'h7, 6'b000001), "R8");
    rd(3'd0, 32'h1, "R6");

    // parity with reporting disabled: still logged
    wr(3'd4, 32'h1);
    wr(3'd5, 32'h1);
    fire(6'b000001, 64'h0, 32'h0, 4'h9, 32'h0);
    expect_out(2, 0, "R8");
    quiet();
    rd(3'd4, st(1, 0, 3'd1, 4'h9, 6'b000001), "R8");

    // parity and time-out together
    wr(3'd4, 32'h1);
    fire(6'b010001, 64'h0, 32'h0, 4'h2, 32'h1111_2222);
    quiet();
    rd(3'd4, st(1, 1, 3'd1, 4'h2, 6'b010001), "R5");
    rd(3'd3, 32'h0, "R9");

    // target-abort, retry and split error together
    wr(3'd4, 32'h1);
    fire(6'b101100, 64'h0, 32'h0, 4'h4, 32'h0);
    expect_out(3, 1, "R7");
    quiet();
    rd(3'd4, st(1, 1, 3'd3, 4'h4, 6'b101100), "R5");

    // split completion error: message kept
    wr(3'd4, 32'h1);
    fire(6'b100000, 64'h0, 32'h0, 4'hb, 32'hcafe_0042);
    expect_out(3, 0, "R7");
    quiet();
    rd(3'd3, 32'hcafe_0042, "R9");
    rd(3'd4, st(1, 0, 3'd6, 4'hb, 6'b100000), "R3");
    expect_out(1, 1, "R10");
    wr(3'd5, 32'h0);
    expect_out(1, 0, "R10");

    // split time-out alone
    wr(3'd4, 32'h1);
    fire(6'b010000, 64'h0, 32'h0, 4'h1, 32'h0000_5a5a);
    quiet();
    rd(3'd3, 32'h0000_5a5a, "R9");
    rd(3'd4, st(1, 0, 3'd5, 4'h1, 6'b010000), "R3");
    expect_out(1, 0, "R10");

    repeat (3) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule